// File: doc/BRIEF.md
# ECMP Adjacency Member Selector

This block picks the next hop for a route that resolves to a remote neighbour. The route lookup hands it three values: an adjacency base index, a group size, and a packet hash computed alongside that lookup. The base index is a global offset into a shared adjacency table, and many routes may point at the same group. The block reduces the hash by the group size to get a local member offset. It adds that offset to the base and reads the table entry at the sum. The entry holds the destination MAC address that goes into the packet and the egress router-interface id, and both are returned with the response.

Requests and responses use valid/ready handshakes with one registered response stage. The table is loaded through a single-cycle write port. Each table entry has its own hit counter. The counter advances when counting is enabled for a request that selects that entry, and it can be read through a combinational read port. Two cases are reported as errors, and both are treated as drops: a group size outside 1 to MAX_GROUP, and a computed address that lands past the end of the table.

Top module: `ecmp_member_select`

## Requirements
- R1: After reset, rspValid is 0, reqReady is 1, every table entry reads as MAC 0 and interface 0, and every hit counter reads 0.
- R2: A request accepted on a clock edge (reqValid and reqReady both high) produces rspValid high after that edge. The response carries the MAC and interface id of the entry at reqBase + (reqHash mod reqSize), with rspErr 0.
- R3: A request with reqSize equal to 0 produces a response with rspErr 1, rspMac 0 and rspRif 0, and changes no counter.
- R4: A request with reqSize greater than MAX_GROUP (8 by default) is handled like a zero size: rspErr 1, zero MAC and interface, and no counter change.
- R5: If reqBase + (reqHash mod reqSize) is at least DEPTH (64 by default), the response has rspErr 1 with zero MAC and interface, and no counter changes.
- R6: On an accepted, error-free request with cntEnable high, the hit counter of the selected entry rises by exactly one. With cntEnable low, no counter changes.
- R7: While rspValid is high and rspReady is low, the response stays valid and unchanged, and reqReady is low.
- R8: When rspReady is high, reqReady is high, so a new request can be accepted on every cycle.
- R9: A write with cfgWrEn high stores cfgWrMac and cfgWrRif at cfgWrAddr on the clock edge. Requests accepted on later edges return the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqBase | input | 6 | Adjacency group base index |
| reqSize | input | 4 | Group member count |
| reqHash | input | 16 | Packet hash |
| cntEnable | input | 1 | Count this selection |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response consumer ready |
| rspMac | output | 48 | Selected destination MAC |
| rspRif | output | 8 | Selected egress interface id |
| rspErr | output | 1 | Drop: bad size or out of range |
| cfgWrEn | input | 1 | Table write enable |
| cfgWrAddr | input | 6 | Table write address |
| cfgWrMac | input | 48 | MAC to write |
| cfgWrRif | input | 8 | Interface id to write |
| cntRdAddr | input | 6 | Counter read address |
| cntRdCount | output | 16 | Hit count of addressed entry |

## Verification
The bench uses the default parameters: a 64-entry table, groups of up to 8 members, 16-bit hashes and 16-bit counters. With these defaults, random bases near the top of the table combined with sizes up to 8 often push the sum past entry 63, which exercises R5. The random sizes also run from 0 to 10, so both illegal-size cases come up often alongside legal ones. The counters are too wide to wrap within the run, so every counter value the bench reads is exact.

// File: rtl/ecmp_pkg.sv
package ecmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // load response register this cycle
    logic countEn;  // bump hit counter of selected entry
  } ctrlStrobe_t;
endpackage

// File: rtl/ecmp_datapath.sv
module ecmp_datapath
  import ecmp_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAC_W     = 48,
  parameter int RIF_W     = 8,
  parameter int HASH_W    = 16,
  parameter int SIZE_W    = 4,
  parameter int MAX_GROUP = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int ENT_W    = MAC_W + RIF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  reqBase,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [HASH_W-1:0] reqHash,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrAddr,
  input  logic [MAC_W-1:0]  cfgWrMac,
  input  logic [RIF_W-1:0]  cfgWrRif,
  input  logic [IDX_W-1:0]  cntRdAddr,
  output logic [CNT_W-1:0]  cntRdCount,
  output logic              selErr,
  output logic [MAC_W-1:0]  rspMac,
  output logic [RIF_W-1:0]  rspRif,
  output logic              rspErr
);
  logic [ENT_W-1:0]  tbl  [DEPTH];
  logic [CNT_W-1:0]  hits [DEPTH];
  logic [HASH_W-1:0] modRes;
  logic [IDX_W:0]    addrSum;
  logic [IDX_W-1:0]  selIdx;
  logic              sizeBad;
  logic              rangeBad;
  logic [ENT_W-1:0]  selEntry;

  // member offset and global address
  always_comb begin
    sizeBad = (reqSize == '0) || (reqSize > SIZE_W'(MAX_GROUP));
    if (reqSize != '0)
      modRes = reqHash % {{(HASH_W-SIZE_W){1'b0}}, reqSize};
    else
      modRes = '0;
    addrSum  = {1'b0, reqBase} + modRes[IDX_W:0];
    rangeBad = (addrSum >= (IDX_W+1)'(DEPTH));
    selErr   = sizeBad || rangeBad;
    selIdx   = addrSum[IDX_W-1:0];
    selEntry = tbl[selIdx];
  end

  // table storage and hit counters, one slice per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        tbl[e] <= '0;
      else if (cfgWrEn && cfgWrAddr == IDX_W'(e))
        tbl[e] <= {cfgWrMac, cfgWrRif};
    end
    always_ff @(posedge clk) begin
      if (!rstN)
        hits[e] <= '0;
      else if (strobe.countEn && selIdx == IDX_W'(e))
        hits[e] <= hits[e] + 1'b1;
    end
  end

  assign cntRdCount = hits[cntRdAddr];

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspMac <= '0;
      rspRif <= '0;
      rspErr <= 1'b0;
    end else if (strobe.accept) begin
      rspErr <= selErr;
      rspMac <= selErr ? '0 : selEntry[ENT_W-1:RIF_W];
      rspRif <= selErr ? '0 : selEntry[RIF_W-1:0];
    end
  end
endmodule

// File: rtl/ecmp_ctrl.sv
module ecmp_ctrl
  import ecmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        cntEnable,
  input  logic        selErr,
  output logic        reqReady,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);
  always_comb begin
    reqReady       = !rspValid || rspReady;
    strobe.accept  = reqValid && reqReady;
    strobe.countEn = strobe.accept && cntEnable && !selErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rspValid <= 1'b0;
    else if (strobe.accept)
      rspValid <= 1'b1;
    else if (rspReady)
      rspValid <= 1'b0;
  end
endmodule

// File: rtl/ecmp_member_select.sv
module ecmp_member_select
  import ecmp_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAC_W     = 48,
  parameter int RIF_W     = 8,
  parameter int HASH_W    = 16,
  parameter int SIZE_W    = 4,
  parameter int MAX_GROUP = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [IDX_W-1:0]  reqBase,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [HASH_W-1:0] reqHash,
  input  logic              cntEnable,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [MAC_W-1:0]  rspMac,
  output logic [RIF_W-1:0]  rspRif,
  output logic              rspErr,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrAddr,
  input  logic [MAC_W-1:0]  cfgWrMac,
  input  logic [RIF_W-1:0]  cfgWrRif,
  input  logic [IDX_W-1:0]  cntRdAddr,
  output logic [CNT_W-1:0]  cntRdCount
);
  ctrlStrobe_t strobe;
  logic        selErr;

  ecmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .cntEnable(cntEnable), .selErr(selErr), .reqReady(reqReady),
    .rspValid(rspValid), .strobe(strobe)
  );

  ecmp_datapath #(
    .DEPTH(DEPTH), .MAC_W(MAC_W), .RIF_W(RIF_W), .HASH_W(HASH_W),
    .SIZE_W(SIZE_W), .MAX_GROUP(MAX_GROUP), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBase(reqBase),
    .reqSize(reqSize), .reqHash(reqHash), .cfgWrEn(cfgWrEn),
    .cfgWrAddr(cfgWrAddr), .cfgWrMac(cfgWrMac), .cfgWrRif(cfgWrRif),
    .cntRdAddr(cntRdAddr), .cntRdCount(cntRdCount), .selErr(selErr),
    .rspMac(rspMac), .rspRif(rspRif), .rspErr(rspErr)
  );
endmodule

// File: rtl/ecmp_select_checker.sv
module ecmp_select_checker #(
  parameter int MAC_W     = 48,
  parameter int RIF_W     = 8,
  parameter int SIZE_W    = 4,
  parameter int MAX_GROUP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [SIZE_W-1:0] reqSize,
  input logic              rspValid,
  input logic              rspReady,
  input logic [MAC_W-1:0]  rspMac,
  input logic [RIF_W-1:0]  rspRif,
  input logic              rspErr
);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  a_r3_zero_size_err: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqSize == '0 |=> rspErr);

  a_r4_big_size_err: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqSize > SIZE_W'(MAX_GROUP) |=> rspErr);

  a_r5_err_no_entry: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr |-> rspMac == '0 && rspRif == '0);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspMac) && $stable(rspRif)
                              && $stable(rspErr));

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |-> !reqReady);

  a_r8_ready_when_drained: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> reqReady);
endmodule

bind ecmp_member_select ecmp_select_checker #(
  .MAC_W(MAC_W), .RIF_W(RIF_W), .SIZE_W(SIZE_W), .MAX_GROUP(MAX_GROUP)
) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqSize(reqSize), .rspValid(rspValid), .rspReady(rspReady),
  .rspMac(rspMac), .rspRif(rspRif), .rspErr(rspErr)
);

// File: tb/tb_ecmp_member_select.sv
module tb_ecmp_member_select;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [5:0]  reqBase = '0;
  logic [3:0]  reqSize = '0;
  logic [15:0] reqHash = '0;
  logic        cntEnable = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [47:0] rspMac;
  logic [7:0]  rspRif;
  logic        rspErr;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgWrAddr = '0;
  logic [47:0] cfgWrMac = '0;
  logic [7:0]  cfgWrRif = '0;
  logic [5:0]  cntRdAddr = '0;
  logic [15:0] cntRdCount;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [47:0] mdlMac [64];
  logic [7:0]  mdlRif [64];
  int          mdlCnt [64];

  always #5 clk = ~clk;

  ecmp_member_select dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected selection: returns -1 on error
  function automatic int expIdx(input int base, input int size, input int hash);
    int s;
    if (size == 0 || size > 8) return -1;
    s = base + (hash % size);
    if (s >= 64) return -1;
    return s;
  endfunction

  task automatic cfgWrite(input int a, input logic [47:0] m, input logic [7:0] r);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = 6'(a); cfgWrMac = m; cfgWrRif = r;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mdlMac[a] = m; mdlRif[a] = r;
  endtask

  task automatic checkResp(input int idx, input string req);
    check(rspValid == 1'b1, req, 64'(rspValid), 64'd1);
    if (idx < 0) begin
      check(rspErr == 1'b1 && rspMac == '0 && rspRif == '0, req,
            {7'd0, rspErr, rspRif, rspMac}, {8'd1, 56'd0});
    end else begin
      check(rspErr == 1'b0 && rspMac == mdlMac[idx] && rspRif == mdlRif[idx], req,
            {7'd0, rspErr, rspRif, rspMac}, {8'd0, mdlRif[idx], mdlMac[idx]});
    end
  endtask

  task automatic doReq(input int base, input int size, input int hash,
                       input bit ce, input string req);
    int idx;
    idx = expIdx(base, size, hash);
    @(negedge clk);
    reqValid = 1'b1; reqBase = 6'(base); reqSize = 4'(size);
    reqHash = 16'(hash); cntEnable = ce;
    @(negedge clk);
    reqValid = 1'b0; cntEnable = 1'b0;
    checkResp(idx, req);
    if (idx >= 0 && ce) mdlCnt[idx]++;
  endtask

  task automatic checkCnt(input int a, input string req);
    cntRdAddr = 6'(a);
    #1;
    check(int'(cntRdCount) == mdlCnt[a], req, 64'(cntRdCount), 64'(mdlCnt[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      mdlMac[i] = '0; mdlRif[i] = '0; mdlCnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(rspValid == 1'b0, "R1 rspValid", 64'(rspValid), 64'd0);
    check(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    checkCnt(17, "R1 counter");
    doReq(3, 1, 0, 1'b0, "R1 table cleared");

    // R9: load table
    for (int i = 0; i < 64; i++)
      cfgWrite(i, {8'(i), 8'hA5, 32'($urandom())}, 8'($urandom()));
    doReq(20, 1, 5, 1'b1, "R9 loaded entry");

    // R3, R4, R5 directed
    doReq(10, 0, 77, 1'b1, "R3 zero size");
    checkCnt(10, "R3 no count");
    doReq(10, 9, 77, 1'b1, "R4 size over max");
    doReq(10, 15, 3, 1'b1, "R4 size 15");
    checkCnt(10, "R4 no count");
    doReq(63, 2, 1, 1'b1, "R5 past end");
    doReq(63, 2, 0, 1'b1, "R5 last entry ok");
    doReq(56, 8, 7, 1'b1, "R2 max group top");
    checkCnt(63, "R6 top counter");

    // R6: counting disabled
    doReq(30, 4, 6, 1'b0, "R6 disabled req");
    checkCnt(32, "R6 disabled no count");

    // R2/R6 random
    for (int n = 0; n < 300; n++) begin
      int b, s, h;
      b = int'($urandom_range(0, 63));
      s = int'($urandom_range(0, 10));
      h = int'($urandom_range(0, 65535));
      doReq(b, s, h, 1'($urandom()), "R2 random select");
      if (n % 10 == 0) checkCnt(int'($urandom_range(0, 63)), "R6 random count");
    end
    for (int i = 0; i < 64; i++) checkCnt(i, "R6 final count");

    // R8: back-to-back acceptance
    @(negedge clk);
    reqValid = 1'b1; reqBase = 6'd4; reqSize = 4'd3; reqHash = 16'd10;
    @(negedge clk);
    check(reqReady == 1'b1, "R8 ready while draining", 64'(reqReady), 64'd1);
    checkResp(5, "R8 first of pair");
    reqBase = 6'd40; reqSize = 4'd5; reqHash = 16'd13;
    @(negedge clk);
    reqValid = 1'b0;
    checkResp(43, "R8 second of pair");

    // R7: backpressure
    @(negedge clk);
    rspReady = 1'b0;
    reqValid = 1'b1; reqBase = 6'd8; reqSize = 4'd2; reqHash = 16'd3;
    @(negedge clk);
    reqBase = 6'd50; reqSize = 4'd1; reqHash = 16'd0;
    check(reqReady == 1'b0, "R7 stalled ready", 64'(reqReady), 64'd0);
    checkResp(9, "R7 held first");
    @(negedge clk);
    @(negedge clk);
    check(reqReady == 1'b0, "R7 still stalled", 64'(reqReady), 64'd0);
    checkResp(9, "R7 still first");
    rspReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkResp(50, "R7 queued second");

    // R9: rewrite then read
    cfgWrite(12, 48'h0123_4567_89AB, 8'h5C);
    doReq(11, 2, 1, 1'b0, "R9 rewritten entry");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule